// File: doc/BRIEF.md
# Priority Vectored Interrupt Arbiter

This block sits between a set of device interrupt-request lines and a processor. Each request line has its own priority level. Every cycle the block chooses one candidate from the active lines: the highest level wins, and the lowest device index breaks a tie. It grants the candidate only when the candidate's level is strictly above the processor's current priority level. That level is held in the block and driven out as the priority field of the processor status word.

A grant does three things. It raises the current level to the granted device's level. It pushes the level that was in force onto a small internal stack. It presents the address of the device's entry in a vector table at the bottom of memory, from which the processor fetches the service-routine address. A return strobe from the end of the service routine pops the stack, which restores the interrupted level. Nested service therefore works: a higher-level device can interrupt a lower-level routine. The table itself is external.

Top module: `irq_prio_arb`

## Requirements
- R1: In reset, and in the first cycle after reset, `cur_lvl`, `grant_vld`, `grant_id` and `vec_addr` are all zero.
- R2: A request is granted only if its level is strictly greater than `cur_lvl`. A request at the same level or a lower level stays pending without a grant, so a device at level 0 is never granted.
- R3: When several requests are active, the candidate is the one with the numerically highest level.
- R4: Among active requests that share the highest level, the lowest device index is chosen.
- R5: A grant is a one-cycle `grant_vld` pulse on the clock edge that samples the request. `grant_id` carries the device index, and `vec_addr` equals the index times 4 (4-byte entries, base address 0, 32 entries covering bytes 0 to 127).
- R6: On the same edge that asserts `grant_vld`, `cur_lvl` becomes the granted device's level.
- R7: A return strobe with at least one grant outstanding sets `cur_lvl`, on the next edge, to the level that was in force before the most recent outstanding grant.
- R8: With `STK_DEPTH` grants outstanding, no further grant is made until a return frees a stack slot.
- R9: A return strobe with no grant outstanding leaves `cur_lvl` unchanged.
- R10: When a return is accepted in a cycle, that cycle makes no grant. Requests are judged against the restored level from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | N_SRC | Level-held request line per device |
| irq_lvl | input | N_SRC*LVL_W | Priority level per device; device i uses bits [i*LVL_W +: LVL_W] |
| ret_i | input | 1 | Return-from-service strobe, one cycle |
| grant_vld | output | 1 | One-cycle grant pulse |
| grant_id | output | ID_W | Index of the granted device |
| vec_addr | output | ADDR_W | Byte address of the granted device's vector entry |
| cur_lvl | output | LVL_W | Current processor priority field of the status word |

## Verification
Each result is due exactly one clock edge after its stimulus. A request sampled at edge k shows `grant_vld`, `grant_id`, `vec_addr` and the raised `cur_lvl` just after edge k. A return sampled at edge k shows the restored `cur_lvl` just after edge k. The bench applies inputs after a falling edge and updates its queue-based model at the rising edge. It compares every output at the following falling edge, which falls within the cycle that the requirements name. Directed phases cover equal and lower levels, level ties, nesting to a full stack, returns with no grant outstanding, and a return in the same cycle as a request. A long random phase follows them.

// File: rtl/irq_prio_pkg.sv
// Shared constants for the priority vectored interrupt arbiter.
// Assumes byte addressing and one vector word per device.
package irq_prio_pkg;
    localparam int VEC_ENTRY_BYTES = 4;
    localparam int VEC_SHIFT       = $clog2(VEC_ENTRY_BYTES);
endpackage

// File: rtl/irq_prio_pick.sv
// Combinational picker: finds the active request with the highest level.
// Ties go to the lowest index. Assumes levels arrive packed, LVL_W bits per device.
module irq_prio_pick #(
    parameter int N_SRC = 32,
    parameter int LVL_W = 3,
    localparam int ID_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]       req,
    input  logic [N_SRC*LVL_W-1:0] lvl,
    output logic                   found,
    output logic [ID_W-1:0]        idx,
    output logic [LVL_W-1:0]       best
);
    // Scan upward; strict compare keeps the lowest index on a tie.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i] && (!found || lvl[i*LVL_W +: LVL_W] > best)) begin
                found = 1'b1;
                idx   = ID_W'(i);
                best  = lvl[i*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/irq_lvl_stack.sv
// LIFO of saved priority levels, one entry per outstanding grant.
// Assumes the owner never pushes when full or pops when empty.
module irq_lvl_stack #(
    parameter int LVL_W = 3,
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] din,
    output logic [LVL_W-1:0] top,
    output logic             full,
    output logic             empty
);
    logic [LVL_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] cnt;

    // Occupancy counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (push) cnt <= cnt + CNT_W'(1);
        else if (pop)  cnt <= cnt - CNT_W'(1);
    end

    // Store the pushed level in the next free slot.
    always_ff @(posedge clk) begin
        if (push) mem[IDX_W'(cnt)] <= din;
    end

    // Present the most recent saved level.
    always_comb top = mem[IDX_W'(cnt - CNT_W'(1))];

    assign full  = (cnt == CNT_W'(DEPTH));
    assign empty = (cnt == '0);

    // R8
    push_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R9
    pop_not_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/irq_prio_arb.sv
// Priority vectored interrupt arbiter top.
// Grants the best request whose level is strictly above the current level,
// raises the level, saves the old one, and emits the vector-table address.
// Assumes devices hold requests until serviced and that ret_i comes once per grant.
module irq_prio_arb
    import irq_prio_pkg::*;
#(
    parameter int N_SRC     = 32,
    parameter int LVL_W     = 3,
    parameter int STK_DEPTH = 4,
    parameter int ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] VEC_BASE = '0,
    localparam int ID_W = $clog2(N_SRC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       irq_req,
    input  logic [N_SRC*LVL_W-1:0] irq_lvl,
    input  logic                   ret_i,
    output logic                   grant_vld,
    output logic [ID_W-1:0]        grant_id,
    output logic [ADDR_W-1:0]      vec_addr,
    output logic [LVL_W-1:0]       cur_lvl
);
    logic             pick_vld;
    logic [ID_W-1:0]  pick_idx;
    logic [LVL_W-1:0] pick_lvl;
    logic [LVL_W-1:0] stk_top;
    logic             stk_full, stk_empty;
    logic             ret_ok, accept;

    irq_prio_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W)) pick_i (
        .req(irq_req), .lvl(irq_lvl),
        .found(pick_vld), .idx(pick_idx), .best(pick_lvl)
    );

    irq_lvl_stack #(.LVL_W(LVL_W), .DEPTH(STK_DEPTH)) stk_i (
        .clk(clk), .rst_n(rst_n), .push(accept), .pop(ret_ok),
        .din(cur_lvl), .top(stk_top), .full(stk_full), .empty(stk_empty)
    );

    // Decide this cycle's action: a valid return beats any grant.
    always_comb begin
        ret_ok = ret_i && !stk_empty;
        accept = pick_vld && (pick_lvl > cur_lvl) && !stk_full && !ret_ok;
    end

    // Register grant outputs and the processor priority level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_vld <= 1'b0;
            grant_id  <= '0;
            vec_addr  <= '0;
            cur_lvl   <= '0;
        end else begin
            grant_vld <= accept;
            if (ret_ok) begin
                cur_lvl <= stk_top;
            end else if (accept) begin
                cur_lvl  <= pick_lvl;
                grant_id <= pick_idx;
                vec_addr <= VEC_BASE + (ADDR_W'(pick_idx) << VEC_SHIFT);
            end
        end
    end

    // R2
    strict_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_vld && pick_lvl <= cur_lvl) |=> !grant_vld);
    // R6
    lvl_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (grant_vld && cur_lvl == $past(pick_lvl)));
    // R7
    lvl_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !stk_empty) |=> (cur_lvl == $past(stk_top) && !grant_vld));
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |=> !grant_vld);
    // R9
    empty_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && stk_empty && !accept) |=> $stable(cur_lvl));
    // R5
    vec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> vec_addr == VEC_BASE + (ADDR_W'(grant_id) << VEC_SHIFT));
endmodule

// File: tb/irq_prio_arb_tb_top.sv
`timescale 1ns/1ps
module irq_prio_arb_tb_top;
    localparam int N  = 32;
    localparam int LW = 3;
    localparam int SD = 4;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          ret = 1'b0;
    logic [2:0]    lvl_cfg [N];
    logic [N*LW-1:0] lvl_flat;
    logic          grant_vld;
    logic [4:0]    grant_id;
    logic [AW-1:0] vec_addr;
    logic [LW-1:0] cur_lvl;

    int errors = 0;
    int checks = 0;
    string tag = "R1";

    int m_cur = 0;
    int m_stk[$];
    bit m_vld = 0;
    int m_id = 0;

    always #2 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) lvl_flat[i*LW +: LW] = lvl_cfg[i];
    end

    irq_prio_arb dut_i (
        .clk(clk), .rst_n(rst_n), .irq_req(req), .irq_lvl(lvl_flat),
        .ret_i(ret), .grant_vld(grant_vld), .grant_id(grant_id),
        .vec_addr(vec_addr), .cur_lvl(cur_lvl)
    );

    task automatic chk(input string t, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
        end
    endtask

    // Reference model step at a rising edge.
    task automatic model_edge();
        int best, id;
        bit found, ret_ok;
        if (!rst_n) begin
            m_cur = 0; m_stk.delete(); m_vld = 0; m_id = 0;
            return;
        end
        found = 0; best = 0; id = 0;
        for (int i = 0; i < N; i++)
            if (req[i] && (!found || int'(lvl_cfg[i]) > best)) begin
                found = 1; best = lvl_cfg[i]; id = i;
            end
        ret_ok = ret && (m_stk.size() > 0);
        m_vld = 0;
        if (ret_ok) m_cur = m_stk.pop_back();
        else if (found && best > m_cur && m_stk.size() < SD) begin
            m_stk.push_back(m_cur);
            m_cur = best; m_vld = 1; m_id = id;
        end
    endtask

    task automatic step(input logic [N-1:0] r, input logic rt);
        req = r; ret = rt;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk(tag, "grant_vld", grant_vld, m_vld);
        chk(tag, "cur_lvl", cur_lvl, m_cur);
        if (m_vld) begin
            chk(tag, "grant_id", grant_id, m_id);
            chk("R5", "vec_addr", vec_addr, m_id * 4);
        end
    endtask

    task automatic drain();
        repeat (SD + 2) step('0, 1'b1);
    endtask

    task automatic clear_lvls();
        for (int i = 0; i < N; i++) lvl_cfg[i] = '0;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        clear_lvls();
        @(negedge clk);
        // R1: reset state
        tag = "R1";
        step('0, 1'b0);
        step('1, 1'b1);
        chk("R1", "vec_addr", vec_addr, 0);
        chk("R1", "grant_id", grant_id, 0);
        rst_n = 1'b1;
        step('0, 1'b0);
        chk("R1", "cur_lvl", cur_lvl, 0);

        // R2: equal and lower levels wait; level 0 never granted
        tag = "R2";
        lvl_cfg[3] = 3'd2; lvl_cfg[9] = 3'd2; lvl_cfg[12] = 3'd1;
        step(32'h1, 1'b0);
        step(32'h8, 1'b0);
        repeat (3) step(32'h1208, 1'b0);
        // R10: return with pending requests, no grant that cycle
        tag = "R10";
        step(32'h1208, 1'b1);
        step(32'h1208, 1'b0);
        tag = "R2";
        drain();

        // R3: highest level wins
        tag = "R3";
        clear_lvls();
        lvl_cfg[20] = 3'd4; lvl_cfg[5] = 3'd6; lvl_cfg[7] = 3'd1;
        step(32'h0010_00A0, 1'b0);
        step(32'h0010_0080, 1'b0);
        drain();

        // R4: tie goes to lowest index
        tag = "R4";
        clear_lvls();
        lvl_cfg[17] = 3'd5; lvl_cfg[11] = 3'd5; lvl_cfg[25] = 3'd5;
        step(32'h0202_0800, 1'b0);
        drain();

        // R5: vector addresses at the table edges
        tag = "R5";
        clear_lvls();
        lvl_cfg[31] = 3'd7; lvl_cfg[0] = 3'd7;
        step(32'h8000_0000, 1'b0);
        drain();
        step(32'h0000_0001, 1'b0);
        drain();

        // R6 / R7: nesting up then unwinding
        tag = "R6";
        clear_lvls();
        lvl_cfg[1] = 3'd1; lvl_cfg[2] = 3'd3; lvl_cfg[4] = 3'd6;
        step(32'h02, 1'b0);
        step(32'h06, 1'b0);
        step(32'h16, 1'b0);
        tag = "R7";
        step(32'h00, 1'b1);
        step(32'h00, 1'b1);
        step(32'h00, 1'b0);
        step(32'h00, 1'b1);

        // R8: stack full withholds grants
        tag = "R8";
        clear_lvls();
        for (int i = 1; i <= 5; i++) lvl_cfg[i] = 3'(i);
        for (int i = 1; i <= 5; i++) step(32'((1 << (i + 1)) - 2), 1'b0);
        step(32'h3E, 1'b0);
        step(32'h3E, 1'b0);
        step(32'h3E, 1'b1);
        step(32'h3E, 1'b0);
        drain();

        // R9: returns with nothing outstanding
        tag = "R9";
        repeat (3) step('0, 1'b1);
        step(32'h2, 1'b1);
        step('0, 1'b1);

        // Mixed random traffic
        tag = "R3";
        for (int n = 0; n < 3000; n++) begin
            logic [N-1:0] r;
            if (n % 200 == 0)
                for (int i = 0; i < N; i++) lvl_cfg[i] = 3'($urandom_range(0, 7));
            r = $urandom() & $urandom() & $urandom();
            step(r, ($urandom_range(0, 4) == 0));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule